// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a word clock that marks the channel, and a data line) and turns it into parallel samples. All three lines are asynchronous to the block's system clock. They pass through a synchronizer, and each data bit is taken on a detected rising edge of the bit clock. Everything else runs in the system clock domain.

A 2-bit format input selects one of four framings. Two framings start the word at the beginning of each word-clock half-period: one has a one-slot delay (I2S) and one has none (left-justified). The other two are right-justified, with 24-bit or 16-bit words that end in the last slot before the next word-clock change. Each channel's word is delivered as a sign-extended 24-bit two's-complement value. A single-cycle strobe marks the moment a complete left/right pair is presented together.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair completes, both sample outputs read zero and the strobe is low.
- R2: With format code 2'b00 (I2S), the left word is carried while the word clock is low. Its MSB arrives in the second bit slot after the word-clock change, and bits follow MSB first.
- R3: With format code 2'b01 (left-justified), the left word is carried while the word clock is high. Its MSB arrives in the first bit slot after the word-clock change.
- R4: With format code 2'b10 (right-justified, 24-bit), the left half is word-clock high. The word is the last 24 bits before the next word-clock change, and earlier bits in the half are ignored.
- R5: With format code 2'b11 (right-justified, 16-bit), the left half is word-clock high. The word is the last 16 bits before the next word-clock change, sign-extended from bit 15 to 24 bits.
- R6: In formats 2'b00 and 2'b01, a word shorter than 24 bits appears in the upper bits of the output, with its missing low bits zero, even when the previous half carried ones there.
- R7: In formats 2'b00 and 2'b01, bits that arrive after the 24th data slot of a half-period do not change the delivered word.
- R8: The strobe is high for exactly one system-clock cycle, when a right word completes at a word-clock change. Left and right outputs change together in that same cycle.
- R9: Outside strobe cycles, neither sample output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| wclk_i | input | 1 | Word clock, level selects channel |
| sdata_i | input | 1 | Serial data, two's complement, MSB first |
| fmt_i | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified 24, 11 right-justified 16 |
| left_o | output | 24 | Left sample, sign-extended two's complement |
| right_o | output | 24 | Right sample, sign-extended two's complement |
| valid_o | output | 1 | One-cycle strobe, new left/right pair |

## Verification
The assertions check, on every cycle, that the strobe never lasts more than one cycle and that strobes are spaced as far apart as two serial word changes require. They also check that the sample outputs stay still outside strobes and that a 16-bit right-justified word always leaves with its upper bits copying bit 15. Only the bench's scenarios can show that each framing puts the right bits in the right channel. The same holds for zero padding of short words and for discarding extra or leading slots, because these depend on the serial waveform the bench drives.

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int W           = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_i,
  input  logic         wclk_i,
  input  logic         sdata_i,
  input  logic [1:0]   fmt_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);

  localparam logic [1:0]       FMT_I2S  = 2'b00;
  localparam logic [CNT_W-1:0] SLOT_MAX = '1;
  localparam logic [CNT_W-1:0] W_C      = CNT_W'(W);

  logic [SYNC_STAGES-1:0] bclk_sh, wclk_sh, sdat_sh;
  logic                   bclk_d, wclk_prev, armed;
  logic [CNT_W-1:0]       slot;
  logic [W-1:0]           asm_q, rj_q, left_hold;

  wire bclk_s    = bclk_sh[SYNC_STAGES-1];
  wire wclk_s    = wclk_sh[SYNC_STAGES-1];
  wire sdat_s    = sdat_sh[SYNC_STAGES-1];
  wire bclk_rise = bclk_s & ~bclk_d;
  wire wclk_edge = wclk_s ^ wclk_prev;

  logic [CNT_W-1:0] offset, cur_slot, rel;
  logic             cap_en, prev_is_left;
  logic [W-1:0]     cap_mask, asm_next, done_word, rj_short;

  assign rj_short = {{(W-SHORT_W){rj_q[SHORT_W-1]}}, rj_q[SHORT_W-1:0]};

  always_comb begin
    offset       = (fmt_i == FMT_I2S) ? CNT_W'(1) : '0;
    cur_slot     = wclk_edge ? '0 : slot;
    rel          = cur_slot - offset;
    cap_en       = !fmt_i[1] && (cur_slot >= offset) && (rel < W_C);
    cap_mask     = {1'b1, {(W-1){1'b0}}} >> rel;
    asm_next     = (wclk_edge ? '0 : asm_q) | ((cap_en && sdat_s) ? cap_mask : '0);
    done_word    = fmt_i[1] ? (fmt_i[0] ? rj_short : rj_q) : asm_q;
    prev_is_left = (fmt_i == FMT_I2S) ? !wclk_prev : wclk_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh   <= '0;
      wclk_sh   <= '0;
      sdat_sh   <= '0;
      bclk_d    <= 1'b0;
      wclk_prev <= 1'b0;
      armed     <= 1'b0;
      slot      <= '0;
      asm_q     <= '0;
      rj_q      <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      bclk_sh <= {bclk_sh[SYNC_STAGES-2:0], bclk_i};
      wclk_sh <= {wclk_sh[SYNC_STAGES-2:0], wclk_i};
      sdat_sh <= {sdat_sh[SYNC_STAGES-2:0], sdata_i};
      bclk_d  <= bclk_s;
      valid_o <= 1'b0;
      if (bclk_rise) begin
        wclk_prev <= wclk_s;
        rj_q      <= {rj_q[W-2:0], sdat_s};
        asm_q     <= asm_next;
        slot      <= (cur_slot == SLOT_MAX) ? SLOT_MAX : cur_slot + CNT_W'(1);
        if (wclk_edge) begin
          armed <= 1'b1;
          if (armed) begin
            if (prev_is_left) begin
              left_hold <= done_word;
            end else begin
              left_o  <= left_hold;
              right_o <= done_word;
              valid_o <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter int W       = 24,
  parameter int SHORT_W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   fmt_i,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o
);

  logic [2:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= 3'd7;
    else if (valid_o)    gap <= 3'd0;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R8
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> gap >= 3'd3); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> ($stable(left_o) && $stable(right_o))); // R9
  AST_SEXT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(fmt_i) == 2'b11) |-> ((right_o[W-1:SHORT_W-1] == '0) || (right_o[W-1:SHORT_W-1] == '1))); // R5

endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.W(W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0;
  int wide_viol = 0, hold_viol = 0;
  bit done = 0;
  logic [23:0] got_l[$], got_r[$];
  logic [23:0] last_l = '0, last_r = '0;
  logic        last_v = 1'b0;

  always #2.5 clk = ~clk;

  pcm_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        got_l.push_back(left_o);
        got_r.push_back(right_o);
      end
      if (valid_o && last_v) wide_viol++;
      if (!valid_o && (left_o != last_l || right_o != last_r)) hold_viol++;
    end
    last_v = valid_o; last_l = left_o; last_r = right_o;
  end

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(logic [1:0] f, logic [23:0] v, int n);
    logic [23:0] m;
    m = v & ((24'h1 << n) - 24'h1);
    if (n >= 24) m = v;
    case (f)
      2'b10:   return m;
      2'b11:   return {{8{m[15]}}, m[15:0]};
      default: return m << (24 - n);
    endcase
  endfunction

  function automatic logic slot_bit(logic [1:0] f, logic [23:0] v, int n, int slots, int s);
    int p;
    if (f[1]) begin
      if (s >= slots - n) return v[slots - 1 - s];
      return 1'b1;
    end
    p = (f == 2'b00) ? s - 1 : s;
    if (p < 0) return 1'b1;
    if (p < n) return v[n - 1 - p];
    if (p >= 24) return 1'b1;
    return 1'b0;
  endfunction

  task automatic send_half(logic lvl, logic [23:0] v, int n, int slots);
    for (int s = 0; s < slots; s++) begin
      wclk  = lvl;
      sdata = slot_bit(fmt, v, n, slots, s);
      repeat (4) @(posedge clk);
      bclk = 1'b1;
      repeat (4) @(posedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic send_frame(logic [23:0] l, logic [23:0] r, int n, int slots);
    logic lvl;
    lvl = (fmt == 2'b00) ? 1'b0 : 1'b1;
    send_half(lvl, l, n, slots);
    send_half(~lvl, r, n, slots);
  endtask

  task automatic run_pair(string req, logic [1:0] f, logic [23:0] l, logic [23:0] r, int n, int slots);
    fmt = f;
    send_frame(24'h5A5A5A, 24'hA5A5A5, n, slots);
    got_l.delete(); got_r.delete();
    send_frame(l, r, n, slots);
    send_frame(24'hFFFFFF, 24'hFFFFFF, n, slots);
    n_chk++;
    if (got_l.size() == 0) begin
      n_fail++;
      $display("FAIL %s R8 no strobe actual=0 expected>=1", req);
    end else begin
      check({req, " left"},  got_l[$], expect_word(f, l, n));
      check({req, " right"}, got_r[$], expect_word(f, r, n));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 left at reset", left_o, 24'h0);
    check("R1 right at reset", right_o, 24'h0);
    check("R1 strobe at reset", {23'h0, valid_o}, 24'h0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 left after release", left_o, 24'h0);
  endtask

  task automatic t_i2s24();  run_pair("R2 R7 i2s 24-bit", 2'b00, 24'hA5C31E, 24'h3B7F01, 24, 32); endtask
  task automatic t_lj24();   run_pair("R3 R7 left-justified 24-bit", 2'b01, 24'h800001, 24'h7FFFFE, 24, 32); endtask
  task automatic t_rj24();   run_pair("R4 right-justified 24-bit", 2'b10, 24'hC0FFEE, 24'h012345, 24, 32); endtask
  task automatic t_rj16();   run_pair("R5 right-justified 16-bit", 2'b11, 24'h008001, 24'h007ABC, 16, 32); endtask
  task automatic t_lj16();   run_pair("R6 left-justified short", 2'b01, 24'h00BEEF, 24'h001234, 16, 16); endtask
  task automatic t_i2s20();  run_pair("R6 i2s short", 2'b00, 24'h0FEDCB, 24'h000ABF, 20, 21); endtask

  task automatic t_strobe();
    check("R8 strobe wider than one cycle", 24'(wide_viol), 24'h0);
    check("R9 output change without strobe", 24'(hold_viol), 24'h0);
  endtask

  initial begin
    t_reset();
    t_i2s24();
    t_lj24();
    t_rj24();
    t_rj16();
    t_lj16();
    t_i2s20();
    t_strobe();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule